// File: doc/BRIEF.md
# Dual-Output Dithered NCO

This block is a numerically controlled oscillator that delivers two sine/cosine pairs on every clock. A 32-bit phase accumulator advances by an active increment word. Software-side updates go through a holding register and reach the accumulator only on a sync strobe, so frequency hops can be lined up with an external event. A small pseudo-random offset can be added to the upper phase field before the 13-bit table address is taken. This spreads the spurs that phase truncation would otherwise produce.

The first pair (A) follows the accumulator phase. The second pair (B) serves two roles. In high-speed mode it is looked up half an increment ahead, which supplies the odd-time samples a double-rate real input stream needs. An optional negation of both B outputs then shifts the odd-time samples by half the input rate. Outside high-speed mode, B is the conjugate of A: same phase, sine negated. A monitor port shows the top half of the active increment and can be frozen. The waveform comes from a quarter-wave table that is computed when the design is elaborated.

Top module: `nco_dual`

## Requirements
- R1: The 32-bit accumulator adds the active increment on every clock edge. While `clear` is high at an edge it becomes zero instead, so a held `clear` keeps the phase at zero.
- R2: For a 13-bit address a, the sine output is round(2047·sin(2π(a+0.5)/8192)) within one LSB, as a 12-bit two's complement value. The cosine is the sine at address (a+2048) mod 8192. Magnitudes never exceed 2047.
- R3: The A address is bits 31..19 of the dithered phase. The accumulator value present after edge k appears on `a_cos`/`a_sin` after edge k+2.
- R4: Dither comes from a 17-bit LFSR with polynomial x^17+x^14+1. Its 4 low bits are added to phase bits 18..15, so the address rises by at most one. While `dith_sync` is high the added value is zero and the LFSR is reloaded to a fixed nonzero seed, so the sequence after release repeats exactly.
- R5: With `hs_en` high, B is looked up at the accumulator plus the increment shifted right arithmetically by one, with the same dither. B is aligned with A. `hs_en` and `neg_odd` travel with the phase they are sampled with.
- R6: With `hs_en` low, `b_cos` equals `a_cos` and `b_sin` equals −`a_sin`.
- R7: With `hs_en` high and `neg_odd` high, both B outputs are negated. With `hs_en` low, `neg_odd` has no effect.
- R8: A `freq_wr` edge loads `freq_in` into the holding register, and a `freq_sync` edge copies the holding register into the active increment. Without a sync, a write changes nothing. When write and sync share an edge, the earlier holding value is the one transferred.
- R9: `mon_inc` takes bits 31..16 of the active increment one edge later while `mon_hold` is low, and keeps its value while `mon_hold` is high.
- R10: While `rst_n` is low, all four waveform outputs and `mon_inc` are zero, and the accumulator, holding and active increments are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_in | input | 32 | New increment word |
| freq_wr | input | 1 | Load `freq_in` into the holding register |
| freq_sync | input | 1 | Transfer holding register to active increment |
| dith_sync | input | 1 | Reseed dither; held high disables dither |
| clear | input | 1 | Force accumulator to zero |
| hs_en | input | 1 | High-speed mode: B pair at half-increment offset |
| neg_odd | input | 1 | Negate both B outputs in high-speed mode |
| mon_hold | input | 1 | Freeze the increment monitor |
| mon_inc | output | 16 | Upper half of active increment |
| a_cos | output | 12 | A cosine, signed |
| a_sin | output | 12 | A sine, signed |
| b_cos | output | 12 | B cosine, signed |
| b_sin | output | 12 | B sine, signed |

## Verification
The waveform outputs lag the accumulator by two edges. The increment monitor lags a sync strobe by two edges: one to update the active register and one to capture it. The bench keeps a reference accumulator with a two-stage delay line, including the mode bits. At every falling edge it compares all four outputs against that delayed phase, so no check depends on manual cycle counting. With dither enabled, the address may rise by one, and each sample is accepted when it matches either the undithered address or the next one. A separate check requires that some samples actually take the shifted value.

// File: rtl/nco_dual.sv
module nco_dual #(
  parameter int PH_W = 32,
  parameter int AW   = 13,
  parameter int OW   = 12,
  parameter int DW   = 17,
  parameter int MW   = 16,
  parameter logic [16:0] SEED = 17'h1B3C5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PH_W-1:0]      freq_in,
  input  logic                 freq_wr,
  input  logic                 freq_sync,
  input  logic                 dith_sync,
  input  logic                 clear,
  input  logic                 hs_en,
  input  logic                 neg_odd,
  input  logic                 mon_hold,
  output logic [MW-1:0]        mon_inc,
  output logic signed [OW-1:0] a_cos,
  output logic signed [OW-1:0] a_sin,
  output logic signed [OW-1:0] b_cos,
  output logic signed [OW-1:0] b_sin
);
  localparam int  QW    = AW - 2;
  localparam int  QN    = 1 << QW;
  localparam int  DBITS = DW - AW;
  localparam int  AMP   = (1 << (OW - 1)) - 1;
  localparam real HPI   = 1.5707963267948966;

  logic [OW-2:0] qrom [QN];

  for (genvar gi = 0; gi < QN; gi++) begin : g_rom
    localparam real ANG = HPI * (real'(gi) + 0.5) / real'(QN);
    localparam int  VAL = $rtoi(real'(AMP) * $sin(ANG) + 0.5);
    assign qrom[gi] = VAL[OW-2:0];
  end

  function automatic logic signed [OW-1:0] trig(input logic [AW-1:0] a);
    logic [QW-1:0] idx;
    logic [OW-1:0] mag;
    idx = a[QW-1:0];
    mag = {1'b0, (a[AW-2] ? qrom[~idx] : qrom[idx])};
    return a[AW-1] ? -$signed(mag) : $signed(mag);
  endfunction

  function automatic logic [AW-1:0] dith_addr(input logic [PH_W-1:0] p,
                                              input logic [DBITS-1:0] d);
    return p[PH_W-1 -: AW] + AW'(p[PH_W-AW-1 -: DBITS] > ~d);
  endfunction

  logic [PH_W-1:0]  hold_inc, act_inc, acc, ph_b;
  logic [16:0]      lfsr;
  logic [DBITS-1:0] dith;
  logic [AW-1:0]    addr_a, addr_b;
  logic             hs_q, neg_q;
  logic signed [OW-1:0] ca, sa, cb, sb;

  assign dith = dith_sync ? '0 : lfsr[DBITS-1:0];
  assign ph_b = hs_en ? acc + PH_W'($signed(act_inc) >>> 1) : acc;

  assign ca = trig(addr_a + AW'(QN));
  assign sa = trig(addr_a);
  assign cb = trig(addr_b + AW'(QN));
  assign sb = trig(addr_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_inc <= '0;
      act_inc  <= '0;
      acc      <= '0;
      mon_inc  <= '0;
      lfsr     <= SEED;
    end else begin
      if (freq_wr)   hold_inc <= freq_in;
      if (freq_sync) act_inc  <= hold_inc;
      acc <= clear ? '0 : acc + act_inc;
      if (!mon_hold) mon_inc <= act_inc[PH_W-1 -: MW];
      lfsr <= dith_sync ? SEED : {lfsr[15:0], lfsr[16] ^ lfsr[13]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_a <= '0;
      addr_b <= '0;
      hs_q   <= 1'b0;
      neg_q  <= 1'b0;
      a_cos  <= '0;
      a_sin  <= '0;
      b_cos  <= '0;
      b_sin  <= '0;
    end else begin
      addr_a <= dith_addr(acc, dith);
      addr_b <= dith_addr(ph_b, dith);
      hs_q   <= hs_en;
      neg_q  <= neg_odd;
      a_cos  <= ca;
      a_sin  <= sa;
      if (hs_q) begin
        b_cos <= neg_q ? -cb : cb;
        b_sin <= neg_q ? -sb : sb;
      end else begin
        b_cos <= cb;
        b_sin <= -sb;
      end
    end
  end
endmodule

module nco_dual_chk #(
  parameter int PH_W = 32,
  parameter int OW   = 12,
  parameter int MW   = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clear,
  input logic                 freq_sync,
  input logic                 mon_hold,
  input logic                 hs_q,
  input logic [PH_W-1:0]      acc,
  input logic [PH_W-1:0]      act_inc,
  input logic [16:0]          lfsr,
  input logic [MW-1:0]        mon_inc,
  input logic signed [OW-1:0] a_cos,
  input logic signed [OW-1:0] a_sin,
  input logic signed [OW-1:0] b_cos,
  input logic signed [OW-1:0] b_sin
);
  localparam logic [OW-1:0] MOST_NEG = {1'b1, {(OW-1){1'b0}}};

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> acc == '0); // R1
  AST_AMP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    a_sin != MOST_NEG && a_cos != MOST_NEG); // R2
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R4
  AST_CONJ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_q |=> (b_sin == -a_sin && b_cos == a_cos)); // R6
  AST_ACTIVE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_sync |=> $stable(act_inc)); // R8
  AST_MON_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    mon_hold |=> $stable(mon_inc)); // R9
endmodule

bind nco_dual nco_dual_chk #(.PH_W(PH_W), .OW(OW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .freq_sync(freq_sync),
  .mon_hold(mon_hold), .hs_q(hs_q), .acc(acc), .act_inc(act_inc),
  .lfsr(lfsr), .mon_inc(mon_inc), .a_cos(a_cos), .a_sin(a_sin),
  .b_cos(b_cos), .b_sin(b_sin)
);

// File: tb/nco_dual_bench.sv
`timescale 1ns/1ps
module nco_dual_bench;
  localparam real PI = 3.141592653589793;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] freq_in = '0;
  logic freq_wr = 0, freq_sync = 0, dith_sync = 1, clear = 0;
  logic hs_en = 0, neg_odd = 0, mon_hold = 0;
  logic [15:0] mon_inc;
  logic signed [11:0] a_cos, a_sin, b_cos, b_sin;

  int n_chk = 0, n_err = 0;
  bit cmp_en = 0;
  string tag_a = "R3";

  always #4 clk = ~clk;

  nco_dual u_nco_dual (
    .clk(clk), .rst_n(rst_n), .freq_in(freq_in), .freq_wr(freq_wr),
    .freq_sync(freq_sync), .dith_sync(dith_sync), .clear(clear),
    .hs_en(hs_en), .neg_odd(neg_odd), .mon_hold(mon_hold),
    .mon_inc(mon_inc), .a_cos(a_cos), .a_sin(a_sin),
    .b_cos(b_cos), .b_sin(b_sin)
  );

  logic [31:0] m_acc, m_act, m_hold, p1, i1, p2, i2;
  logic h1, n1, h2, n2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= '0; m_act <= '0; m_hold <= '0;
      p1 <= '0; i1 <= '0; p2 <= '0; i2 <= '0;
      h1 <= 0; n1 <= 0; h2 <= 0; n2 <= 0;
    end else begin
      p2 <= p1; i2 <= i1; h2 <= h1; n2 <= n1;
      p1 <= m_acc; i1 <= m_act; h1 <= hs_en; n1 <= neg_odd;
      m_acc <= clear ? '0 : m_acc + m_act;
      if (freq_sync) m_act <= m_hold;
      if (freq_wr) m_hold <= freq_in;
    end
  end

  function automatic int sinv(int a);
    real x;
    x = 2047.0 * $sin(2.0 * PI * (real'(a & 8191) + 0.5) / 8192.0);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic chk(string req, string nm, int act, int exp, int tol);
    n_chk++;
    if (act - exp > tol || exp - act > tol) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, nm, act, exp);
    end
  endtask

  task automatic cmp();
    logic [31:0] pb;
    int a, b, ec, es;
    string rb;
    a  = int'(p2[31:19]);
    pb = h2 ? p2 + 32'($signed(i2) >>> 1) : p2;
    b  = int'(pb[31:19]);
    chk(tag_a, "a_cos", int'(a_cos), sinv(a + 2048), 1);
    chk(tag_a, "a_sin", int'(a_sin), sinv(a), 1);
    ec = sinv(b + 2048);
    es = sinv(b);
    if (h2) begin
      rb = n2 ? "R7" : "R5";
      if (n2) begin ec = -ec; es = -es; end
    end else begin
      rb = n2 ? "R7 R6" : "R6";
      es = -es;
    end
    chk(rb, "b_cos", int'(b_cos), ec, 1);
    chk(rb, "b_sin", int'(b_sin), es, 1);
  endtask

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      if (cmp_en) cmp();
    end
  endtask

  task automatic load(logic [31:0] v);
    freq_in = v; freq_wr = 1; cyc(1);
    freq_wr = 0; freq_sync = 1; cyc(1);
    freq_sync = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  int seq1[40], seq2[40];

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", "a_cos", int'(a_cos), 0, 0);
    chk("R10", "a_sin", int'(a_sin), 0, 0);
    chk("R10", "b_cos", int'(b_cos), 0, 0);
    chk("R10", "b_sin", int'(b_sin), 0, 0);
    chk("R10", "mon_inc", int'(mon_inc), 0, 0);
    rst_n = 1;
    cmp_en = 1;
    cyc(2);

    // R8: write alone leaves the active increment untouched
    freq_in = 32'h0008_0000; freq_wr = 1; cyc(1); freq_wr = 0;
    cyc(3);
    chk("R8", "mon_inc no sync", int'(mon_inc), 0, 0);
    freq_sync = 1; cyc(1); freq_sync = 0; cyc(1);
    chk("R9", "mon_inc after sync", int'(mon_inc), 16'h0008, 0);

    // R1: held clear pins phase at zero
    clear = 1; cyc(5);
    chk("R1", "a_sin at zero", int'(a_sin), 1, 0);
    chk("R1", "a_cos at zero", int'(a_cos), 2047, 0);

    // R2: exhaustive table sweep, one address per clock
    hs_en = 1; clear = 0; tag_a = "R2";
    cyc(8192 + 8);
    tag_a = "R3";

    // R5: odd increment in high-speed mode
    load(32'h0123_4567); cyc(1000);
    // R5 R7: negative increment, odd-time negation
    neg_odd = 1; load(32'hF876_5431); cyc(1000);
    // R6 R7: conjugate mode, negation must not matter
    hs_en = 0; cyc(500);
    neg_odd = 0; cyc(300);

    // R8: write and sync on one edge transfers the older holding value
    freq_in = 32'h5A5A_0000; freq_wr = 1; cyc(1);
    freq_in = 32'hC3C3_0000; freq_sync = 1; cyc(1);
    freq_wr = 0; freq_sync = 0; cyc(1);
    chk("R8", "mon_inc same edge", int'(mon_inc), 16'h5A5A, 0);

    // R9: monitor frozen while hold is high
    mon_hold = 1; load(32'h1111_0000); cyc(3);
    chk("R9", "mon_inc held", int'(mon_inc), 16'h5A5A, 0);
    mon_hold = 0; cyc(1);
    chk("R9", "mon_inc released", int'(mon_inc), 16'h1111, 0);

    // R4: dither on, address may rise by one
    hs_en = 1; load(32'h0007_8000);
    clear = 1; cyc(4); clear = 0;
    cmp_en = 0; dith_sync = 0;
    begin
      int shifted = 0;
      cyc(3);
      for (int k = 0; k < 600; k++) begin
        int a, lo, hi, s;
        @(negedge clk);
        a = int'(p2[31:19]);
        lo = sinv(a); hi = sinv(a + 1);
        s = int'(a_sin);
        if (lo > hi) begin int t = lo; lo = hi; hi = t; end
        chk("R4", "dithered a_sin", s, (s < lo) ? lo : ((s > hi) ? hi : s), 1);
        if (s - sinv(a) > 1 || sinv(a) - s > 1) shifted++;
      end
      n_chk++;
      if (shifted == 0) begin
        n_err++;
        $display("FAIL R4 dither visible: got %0d expected >0", shifted);
      end
    end

    // R4: reseeding makes the dithered sequence repeat
    for (int run = 0; run < 2; run++) begin
      dith_sync = 1; clear = 1; cyc(4);
      dith_sync = 0; clear = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (run == 0) seq1[k] = int'(a_sin); else seq2[k] = int'(a_sin);
      end
    end
    for (int k = 0; k < 40; k++) chk("R4", "repeat a_sin", seq2[k], seq1[k], 0);

    // R4: dither held off gives the exact undithered result again
    dith_sync = 1; cyc(3); cmp_en = 1; cyc(200);

    finish_run();
  end
endmodule